// File: doc/BRIEF.md
# Three-Bus Multi-Cycle Instruction Sequencer

This block is the control core of a small load/store processor built around three shared buses. Two buses carry operands into a single ALU. The third bus carries the ALU result back to the program counter or to the register file. A Moore state machine moves through a fetch step and a program-counter increment step. It then decodes the 4-bit opcode held in the instruction register and takes one or two execute steps before it returns to fetch.

The program counter has no adder of its own. It advances by passing through the shared ALU with an increment function. A jump-and-link runs as two ALU passes that both add hard-wired register zero: the first pass copies the program counter into the return-address register, and the second loads the zero-extended 20-bit immediate into the program counter. A minimal register file, ALU and program counter are included. The result bus and the program-counter and return-address values are brought out so that architectural results can be observed.

Top module: `seq_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state becomes fetch (`state_o` = 0), the program counter becomes 0 and every register becomes 0.
- R2: Fetch (`state_o` = 0) asserts only `pc_to_a`, `ir_load` and `mem_read`. All selects are 0 and `alu_fn` is add (0). The instruction register captures `insn_word` at the closing edge.
- R3: Increment (`state_o` = 1) asserts `pc_to_a`, `alu_to_c` and `pc_load`, with `alu_fn` = increment (4). The program counter becomes its old value plus 1.
- R4: At the end of increment, the state machine branches on the opcode field, which is bits 31:28. Opcode 0000 goes to ALU execute (2), 0100 goes to jump (4), 0110 goes to save-link (3), and any other opcode returns to fetch with no register or program-counter write.
- R5: ALU execute drives register port A (`sel_a` = bits 23:20) onto bus A, register port B (`sel_b` = bits 3:0) onto bus B, and writes bus C into `sel_c` = bits 27:24. The function is bits 17:16: 00 add, 01 subtract, 10 AND, 11 OR.
- R6: Save-link (3) asserts `pc_to_a`, `rf_to_b` with `sel_b` = 0, `alu_to_c` and `rf_load` with `sel_c` = 15, using add. Register 15 receives the program counter. The next state is jump.
- R7: Jump (4) asserts `imm_to_b`, `rf_to_a` with `sel_a` = 0, `alu_to_c` and `pc_load`, using add. The program counter receives bits 19:0 of the instruction, zero-extended.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: Each operand bus has at most one driver in any cycle. A bus with no driver reads as zero.
- R10: Every execute state (2 and 4) is followed by fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_word | input | 32 | Instruction word returned by memory during fetch |
| state_o | output | 3 | Current step: 0 fetch, 1 increment, 2 ALU, 3 save-link, 4 jump |
| pc_to_a | output | 1 | Program counter drives bus A |
| rf_to_a | output | 1 | Register port A drives bus A |
| imm_to_b | output | 1 | Zero-extended immediate drives bus B |
| rf_to_b | output | 1 | Register port B drives bus B |
| alu_to_c | output | 1 | ALU result drives bus C |
| pc_load | output | 1 | Program counter loads from bus C |
| ir_load | output | 1 | Instruction register loads `insn_word` |
| rf_load | output | 1 | Register `sel_c` loads from bus C |
| mem_read | output | 1 | Memory read request |
| sel_a | output | 4 | Register port A index |
| sel_b | output | 4 | Register port B index |
| sel_c | output | 4 | Register write index |
| alu_fn | output | 3 | ALU function: 0 add, 1 sub, 2 and, 3 or, 4 increment |
| bus_c | output | 32 | Result bus value |
| pc_val | output | 32 | Program counter value |
| ra_val | output | 32 | Register 15 value |

## Verification
In ALU execute, the register file is read and written in the same cycle. When the destination equals a source, the operand must be the value held before the edge, and the new value must appear only afterwards. Random field choice over 16 registers makes this overlap frequent, and directed instructions with rd equal to rs force it. The reference model computes the result from pre-edge register contents and then checks the effect through later reads on `bus_c` and `ra_val`. Save-link is a second overlap case: it reads the program counter and writes register 15 in one cycle, and the bench judges it by comparing `ra_val` with the model's program counter.

// File: rtl/seq_pkg.sv
// Package: shared step and ALU-function encodings for the sequencer.
// Assumes a 4-bit opcode in the top bits of the instruction word.
package seq_pkg;
    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_INC   = 3'd1,
        ST_ALU   = 3'd2,
        ST_LINK  = 3'd3,
        ST_JUMP  = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_INC = 3'd4
    } alu_fn_e;

    localparam logic [3:0] OP_REG  = 4'b0000;
    localparam logic [3:0] OP_JMP  = 4'b0100;
    localparam logic [3:0] OP_JAL  = 4'b0110;
endpackage

// File: rtl/seq_alu.sv
// Module: combinational ALU shared by every step of the sequencer.
// Assumes the function code comes straight from the controller.
module seq_alu #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        fn,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result
);
    import seq_pkg::*;

    // Select the arithmetic or logic result for the current step.
    always_comb begin
        case (alu_fn_e'(fn))
            FN_SUB:  result = op_a - op_b;
            FN_AND:  result = op_a & op_b;
            FN_OR:   result = op_a | op_b;
            FN_INC:  result = op_a + {{(DATA_W-1){1'b0}}, 1'b1};
            default: result = op_a + op_b;
        endcase
    end
endmodule

// File: rtl/seq_regfile.sv
// Module: register file with two read ports, one write port and a fixed
// read port for the link register. Entry 0 is hard-wired to zero.
// Assumes a synchronous active-low reset that clears every entry.
module seq_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int SEL_W = $clog2(NREG),
    localparam int RA_IDX = NREG - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rsel_a,
    input  logic [SEL_W-1:0]  rsel_b,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] ra_data
);
    logic [DATA_W-1:0] mem [NREG];

    // Clear on reset, otherwise write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && wsel != '0) begin
            mem[wsel] <= wdata;
        end
    end

    // Read ports: entry zero forced to zero.
    always_comb begin
        rdata_a = (rsel_a == '0) ? '0 : mem[rsel_a];
        rdata_b = (rsel_b == '0) ? '0 : mem[rsel_b];
        ra_data = mem[RA_IDX];
    end

    // R8
    zero_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel_a == '0) |-> (rdata_a == '0));
    // R8
    zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && we && wsel == '0) |=> (mem[0] == '0));
endmodule

// File: rtl/seq_ctrl.sv
// Module: Moore controller that holds the instruction register and drives
// every bus enable, load, select and ALU function for each step.
// Assumes an opcode in the top 4 bits, rd/rs just below it, rt in the low
// bits, the ALU sub-function at bits 17:16 and the immediate in the low
// IMM_W bits.
module seq_ctrl #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int IMM_W  = 20,
    localparam int SEL_W = $clog2(NREG),
    localparam int FN_LSB = 16,
    localparam logic [SEL_W-1:0] RA_SEL = SEL_W'(NREG - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] insn_word,
    output logic [2:0]        state_o,
    output logic              pc_to_a,
    output logic              rf_to_a,
    output logic              imm_to_b,
    output logic              rf_to_b,
    output logic              alu_to_c,
    output logic              pc_load,
    output logic              ir_load,
    output logic              rf_load,
    output logic              mem_read,
    output logic [SEL_W-1:0]  sel_a,
    output logic [SEL_W-1:0]  sel_b,
    output logic [SEL_W-1:0]  sel_c,
    output logic [2:0]        alu_fn,
    output logic [IMM_W-1:0]  imm_o
);
    import seq_pkg::*;

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] ir_q;
    logic [3:0]        opcode;

    assign opcode  = ir_q[DATA_W-1 -: 4];
    assign imm_o   = ir_q[IMM_W-1:0];
    assign state_o = state_q;

    // Capture the instruction word during fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)       ir_q <= '0;
        else if (ir_load) ir_q <= insn_word;
    end

    // Advance the step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Choose the next step from the current step and the opcode.
    always_comb begin
        case (state_q)
            ST_FETCH: state_d = ST_INC;
            ST_INC: begin
                case (opcode)
                    OP_REG:  state_d = ST_ALU;
                    OP_JMP:  state_d = ST_JUMP;
                    OP_JAL:  state_d = ST_LINK;
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_LINK: state_d = ST_JUMP;
            default: state_d = ST_FETCH;
        endcase
    end

    // Drive the control word for the current step.
    always_comb begin
        pc_to_a = 1'b0; rf_to_a = 1'b0; imm_to_b = 1'b0; rf_to_b = 1'b0;
        alu_to_c = 1'b0; pc_load = 1'b0; ir_load = 1'b0; rf_load = 1'b0;
        mem_read = 1'b0;
        sel_a = '0; sel_b = '0; sel_c = '0;
        alu_fn = FN_ADD;
        case (state_q)
            ST_FETCH: begin
                pc_to_a = 1'b1; ir_load = 1'b1; mem_read = 1'b1;
            end
            ST_INC: begin
                pc_to_a = 1'b1; alu_to_c = 1'b1; pc_load = 1'b1;
                alu_fn = FN_INC;
            end
            ST_ALU: begin
                rf_to_a = 1'b1; rf_to_b = 1'b1; alu_to_c = 1'b1; rf_load = 1'b1;
                sel_c  = ir_q[DATA_W-5 -: SEL_W];
                sel_a  = ir_q[DATA_W-5-SEL_W -: SEL_W];
                sel_b  = ir_q[SEL_W-1:0];
                alu_fn = {1'b0, ir_q[FN_LSB+1:FN_LSB]};
            end
            ST_LINK: begin
                pc_to_a = 1'b1; rf_to_b = 1'b1; alu_to_c = 1'b1; rf_load = 1'b1;
                sel_c = RA_SEL;
            end
            ST_JUMP: begin
                imm_to_b = 1'b1; rf_to_a = 1'b1; alu_to_c = 1'b1; pc_load = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    exec_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (state_q == ST_ALU || state_q == ST_JUMP)) |=> (state_q == ST_FETCH));
    // R6
    link_then_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_q == ST_LINK) |=> (state_q == ST_JUMP));
    // R4
    undecoded_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_q == ST_INC && opcode != OP_REG && opcode != OP_JMP
         && opcode != OP_JAL) |=> (state_q == ST_FETCH && !rf_load && !pc_load));
    // R2
    fetch_then_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_q == ST_FETCH) |=> (state_q == ST_INC && ir_q == $past(insn_word)));
endmodule

// File: rtl/seq_core.sv
// Module: top of the sequencer. Holds the program counter, muxes the two
// operand buses from their one-hot enables and feeds the result bus back.
// Assumes a synchronous active-low reset; undriven buses read as zero.
module seq_core #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int IMM_W  = 20,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] insn_word,
    output logic [2:0]        state_o,
    output logic              pc_to_a,
    output logic              rf_to_a,
    output logic              imm_to_b,
    output logic              rf_to_b,
    output logic              alu_to_c,
    output logic              pc_load,
    output logic              ir_load,
    output logic              rf_load,
    output logic              mem_read,
    output logic [SEL_W-1:0]  sel_a,
    output logic [SEL_W-1:0]  sel_b,
    output logic [SEL_W-1:0]  sel_c,
    output logic [2:0]        alu_fn,
    output logic [DATA_W-1:0] bus_c,
    output logic [DATA_W-1:0] pc_val,
    output logic [DATA_W-1:0] ra_val
);
    logic [DATA_W-1:0] pc_q, bus_a, bus_b, rf_a, rf_b, imm_ext;
    logic [IMM_W-1:0]  imm;

    seq_ctrl #(.DATA_W(DATA_W), .NREG(NREG), .IMM_W(IMM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .insn_word(insn_word), .state_o(state_o),
        .pc_to_a(pc_to_a), .rf_to_a(rf_to_a), .imm_to_b(imm_to_b),
        .rf_to_b(rf_to_b), .alu_to_c(alu_to_c), .pc_load(pc_load),
        .ir_load(ir_load), .rf_load(rf_load), .mem_read(mem_read),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .alu_fn(alu_fn),
        .imm_o(imm)
    );

    seq_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .rsel_a(sel_a), .rsel_b(sel_b),
        .we(rf_load), .wsel(sel_c), .wdata(bus_c),
        .rdata_a(rf_a), .rdata_b(rf_b), .ra_data(ra_val)
    );

    seq_alu #(.DATA_W(DATA_W)) u_alu (
        .fn(alu_fn), .op_a(bus_a), .op_b(bus_b), .result(bus_c)
    );

    assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
    assign pc_val  = pc_q;

    // Operand bus muxes: one-hot enables, zero when nothing drives.
    always_comb begin
        bus_a = pc_to_a  ? pc_q    : (rf_to_a ? rf_a : '0);
        bus_b = imm_to_b ? imm_ext : (rf_to_b ? rf_b : '0);
    end

    // Program counter loads from the result bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= bus_c;
    end

    // R9
    bus_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_to_a, rf_to_a}));
    // R9
    bus_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imm_to_b, rf_to_b}));
    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_o == 3'd1) |=> (pc_q == $past(pc_q) + 1'b1));
    // R7
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_o == 3'd4) |=> (pc_q == $past(imm_ext)));
    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && state_o == 3'd3) |=> (ra_val == $past(pc_q)));
    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pc_load) |=> $stable(pc_q));
endmodule

// File: tb/seq_core_test.sv
module seq_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_word = '0;
    logic [2:0]  state_o, alu_fn;
    logic        pc_to_a, rf_to_a, imm_to_b, rf_to_b, alu_to_c;
    logic        pc_load, ir_load, rf_load, mem_read;
    logic [3:0]  sel_a, sel_b, sel_c;
    logic [31:0] bus_c, pc_val, ra_val;

    int errors = 0;
    int checks = 0;
    logic [31:0] mregs [16];
    logic [31:0] mpc;

    always #4 clk = ~clk;

    seq_core uut (
        .clk(clk), .rst_n(rst_n), .insn_word(insn_word), .state_o(state_o),
        .pc_to_a(pc_to_a), .rf_to_a(rf_to_a), .imm_to_b(imm_to_b),
        .rf_to_b(rf_to_b), .alu_to_c(alu_to_c), .pc_load(pc_load),
        .ir_load(ir_load), .rf_load(rf_load), .mem_read(mem_read),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .alu_fn(alu_fn),
        .bus_c(bus_c), .pc_val(pc_val), .ra_val(ra_val)
    );

    wire [23:0] act_ctl = {pc_to_a, rf_to_a, imm_to_b, rf_to_b, alu_to_c,
                           pc_load, ir_load, rf_load, mem_read,
                           sel_a, sel_b, sel_c, alu_fn};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected control word per step, from the requirement text.
    function automatic logic [23:0] exp_ctl(input logic [2:0] st, input logic [31:0] ins);
        case (st)
            3'd0: return {9'b100000101, 4'd0, 4'd0, 4'd0, 3'd0};
            3'd1: return {9'b100011000, 4'd0, 4'd0, 4'd0, 3'd4};
            3'd2: return {9'b010110010, ins[23:20], ins[3:0], ins[27:24], 1'b0, ins[17:16]};
            3'd3: return {9'b100110010, 4'd0, 4'd0, 4'd15, 3'd0};
            default: return {9'b011011000, 4'd0, 4'd0, 4'd0, 3'd0};
        endcase
    endfunction

    function automatic logic [31:0] alu_ref(input logic [1:0] f, input logic [31:0] a,
                                            input logic [31:0] b);
        case (f)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic string step_req(input logic [2:0] st);
        case (st)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mregs[i] = '0;
        mpc = '0;
    endtask

    // Run one instruction step by step; called at a negedge in fetch.
    task automatic run_insn(input logic [31:0] ins, input string alu_req);
        logic [2:0] seq [4];
        int n;
        logic [31:0] expc;
        string req;
        insn_word = ins;
        seq[0] = 3'd0; seq[1] = 3'd1; n = 2;
        case (ins[31:28])
            4'b0000: begin seq[2] = 3'd2; n = 3; end
            4'b0100: begin seq[2] = 3'd4; n = 3; end
            4'b0110: begin seq[2] = 3'd3; seq[3] = 3'd4; n = 4; end
            default: n = 2;
        endcase
        for (int i = 0; i < n; i++) begin
            req = (seq[i] == 3'd2) ? alu_req : step_req(seq[i]);
            chk((i == 2) ? "R4" : req, "state", {29'd0, state_o}, {29'd0, seq[i]});
            chk(req, "ctl", {8'd0, act_ctl}, {8'd0, exp_ctl(seq[i], ins)});
            case (seq[i])
                3'd0: begin expc = mpc;      chk("R9", "bus_c", bus_c, expc); end
                3'd1: begin expc = mpc + 1;  chk("R3", "bus_c", bus_c, expc); mpc = expc; end
                3'd2: begin
                    expc = alu_ref(ins[17:16], mregs[ins[23:20]], mregs[ins[3:0]]);
                    chk(req, "bus_c", bus_c, expc);
                    if (ins[27:24] != 4'd0) mregs[ins[27:24]] = expc;
                end
                3'd3: begin expc = mpc; chk("R6", "bus_c", bus_c, expc); mregs[15] = expc; end
                default: begin expc = {12'd0, ins[19:0]}; chk("R7", "bus_c", bus_c, expc); mpc = expc; end
            endcase
            @(posedge clk);
            @(negedge clk);
            chk(req, "pc", pc_val, mpc);
            chk(req, "ra", ra_val, mregs[15]);
        end
        chk((n == 2) ? "R4" : "R10", "return to fetch", {29'd0, state_o}, 32'd0);
    endtask

    function automatic logic [31:0] rand_insn();
        logic [31:0] w;
        int k;
        w = $urandom;
        k = $urandom % 8;
        if (k < 4)       w[31:28] = 4'b0000;
        else if (k == 4) w[31:28] = 4'b0100;
        else if (k == 5) w[31:28] = 4'b0110;
        if (k == 3) w[23:20] = w[27:24];
        return w;
    endfunction

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", "state", {29'd0, state_o}, 32'd0);
        chk("R1", "pc", pc_val, 32'd0);
        chk("R1", "ra", ra_val, 32'd0);
        rst_n = 1'b1;
        run_insn(32'hA000_0000, "R5");                      // undecoded: R4
        run_insn(32'h6000_0123, "R5");                      // link then jump
        run_insn({4'h0, 4'h0, 4'hF, 2'b00, 2'b00, 16'h000F}, "R8"); // write r0
        run_insn({4'h0, 4'h5, 4'h0, 2'b00, 2'b00, 16'h0000}, "R8"); // read r0
        run_insn({4'h0, 4'h3, 4'hF, 2'b00, 2'b01, 16'h000F}, "R5"); // sub to zero
        run_insn({4'h0, 4'hF, 4'hF, 2'b00, 2'b00, 16'h000F}, "R5"); // rd == rs
        run_insn(32'h4FFF_FFFF, "R5");                      // max immediate
        run_insn(32'h7000_0000, "R5");                      // neighbour opcode
        for (int i = 0; i < 150; i++) run_insn(rand_insn(), "R5");
        // Reset in mid-program: R1
        insn_word = 32'h6000_0042;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "state", {29'd0, state_o}, 32'd0);
        chk("R1", "pc", pc_val, 32'd0);
        chk("R1", "ra", ra_val, 32'd0);
        model_reset();
        rst_n = 1'b1;
        run_insn(32'h6000_0042, "R5");
        run_insn({4'h0, 4'h2, 4'hF, 2'b00, 2'b11, 16'h000F}, "R5");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule